// File: doc/BRIEF.md
# Down-Up Reload PWM Generator

This block produces a pulse-width-modulated drive signal from one 8-bit programmed value. A modulo divider turns the system clock into a slow clock-enable tick, by default about 313 kHz from a 100 MHz clock. The waveform is built on that tick. A small write port holds two registers: the value register and a control register. Bit 0 of the control register starts and stops generation.

Each period has two phases. In the low phase a counter is loaded with the value and counts down, and the output is held low until the counter passes below zero. The counter is then reloaded with the value and counts up, and the output is driven high until the counter passes its maximum. The counter then reloads again and the low phase repeats. With value V, the low phase lasts V+1 ticks and the high phase lasts 256−V ticks, so every period is 257 ticks long and the duty cycle follows V.

Software loads the value first and then sets the start bit. Writing a new value while the generator runs changes the waveform at the next phase change. Clearing the start bit parks the counter and forces the output low.

Top module: `dupwm_gen`

## Requirements
- R1: After reset, `pwm_out` is low, both registers are zero and generation is stopped.
- R2: While the start bit (bit 0 of the control register, written with `wr_addr`=1) is clear, `pwm_out` stays low. Writing the value register (`wr_addr`=0) does not change this, and neither does writing other control bits while bit 0 is 0.
- R3: In steady running with value V, every low phase of `pwm_out` lasts exactly V+1 ticks.
- R4: In steady running with value V, every high phase of `pwm_out` lasts exactly 256−V ticks, so one period is 257 ticks.
- R5: The boundary values work. V=0 gives a low phase of 1 tick and a high phase of 256 ticks. V=255 gives a low phase of 256 ticks and a high phase of 1 tick.
- R6: Setting the start bit always begins a fresh low phase loaded from the current value. The first rising edge of `pwm_out` comes V+1 ticks after the load, and the load happens two clocks after the write.
- R7: A value written while generation runs leaves the phase in progress unchanged. Both later phases use the new value, starting from the next reload.
- R8: Clearing the start bit stops generation. Even in a high phase, `pwm_out` goes low within two clocks of the write and stays low with no further edges.
- R9: The tick occurs once every DIV system clocks, so every phase length is a whole multiple of DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 1 | Register select: 0 = value register, 1 = control register |
| wr_data | input | 8 | Write data; in the control register only bit 0 (start) is used |
| pwm_out | output | 1 | Pulse-width-modulated drive output |

## Verification
The hardest case to reach from the ports is a value write that lands inside a phase that is already running. To be meaningful, the write must fall inside the low phase in one case and inside the high phase in another. The bench queues the expected phase lengths in advance and watches the queue drain. When the queue shows that a particular phase has just begun, it issues the write, so a write lands once in a low phase and once in a high phase. The expected lengths show the old value for the phase in progress and the new value afterwards. Stopping in the middle of a high phase is reached the same way, and the bench then checks that no further edge appears.

// File: rtl/dupwm_pkg.sv
`timescale 1ns/1ps
package dupwm_pkg;

    // Architectural width of the programmed value and the phase counter
    localparam int unsigned VAL_W = 8;

    // Register select codes on the write port
    localparam logic ADDR_VALUE = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;

    // Control register field carrying the start flag
    localparam int unsigned CTRL_GO_BIT = 0;

    typedef logic [VAL_W-1:0] val_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        val_t   cnt;
    } core_st_t;

    localparam core_st_t CORE_PARKED = '{phase: PH_IDLE, cnt: '0};

    // Counter is at the bottom: the next down step underflows
    function automatic logic at_bottom(val_t c);
        return c == '0;
    endfunction

    // Counter is at the top: the next up step overflows
    function automatic logic at_top(val_t c);
        return c == '1;
    endfunction

endpackage

// File: rtl/dupwm_tick.sv
`timescale 1ns/1ps
module dupwm_tick #(
    parameter int unsigned DIV = 320
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_passthru
            // Divide by one: the enable is always active
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign tick = 1'b1;
        end else begin : g_divider
            logic [CW-1:0] div_q;
            logic          wrap;

            assign wrap = (div_q == CW'(DIV - 1));

            always_ff @(posedge clk) begin
                if (rst)       div_q <= '0;
                else if (wrap) div_q <= '0;
                else           div_q <= div_q + 1'b1;
            end

            assign tick = wrap;
        end
    endgenerate

endmodule

// File: rtl/dupwm_regs.sv
`timescale 1ns/1ps
module dupwm_regs
    import dupwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_addr,
    input  val_t wr_data,
    output val_t value_o,
    output logic go_o
);
    val_t value_q;
    logic go_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            go_q    <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_VALUE) value_q <= wr_data;
            else                       go_q    <= wr_data[CTRL_GO_BIT];
        end
    end

    assign value_o = value_q;
    assign go_o    = go_q;

endmodule

// File: rtl/dupwm_core.sv
`timescale 1ns/1ps
module dupwm_core
    import dupwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     go,
    input  val_t     value,
    output core_st_t st_o,
    output logic     pwm_o
);
    core_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!go) begin
            st_d = CORE_PARKED;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: st_d = '{phase: PH_LOW, cnt: value};
                PH_LOW: begin
                    if (tick) begin
                        if (at_bottom(st_q.cnt)) st_d = '{phase: PH_HIGH, cnt: value};
                        else                     st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (at_top(st_q.cnt)) st_d = '{phase: PH_LOW, cnt: value};
                        else                  st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d = CORE_PARKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CORE_PARKED;
        else     st_q <= st_d;
    end

    assign st_o  = st_q;
    assign pwm_o = (st_q.phase == PH_HIGH);

endmodule

// File: rtl/dupwm_gen.sv
`timescale 1ns/1ps
module dupwm_gen
    import dupwm_pkg::*;
#(
    parameter int unsigned DIV = 320
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [VAL_W-1:0] wr_data,
    output logic             pwm_out
);
    logic     tick;
    logic     go_q;
    val_t     value_q;
    core_st_t core_st;

    dupwm_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dupwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .value_o (value_q),
        .go_o    (go_q)
    );

    dupwm_core u_core (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .go    (go_q),
        .value (value_q),
        .st_o  (core_st),
        .pwm_o (pwm_out)
    );

endmodule

// File: rtl/dupwm_gen_chk.sv
`timescale 1ns/1ps
module dupwm_gen_chk
    import dupwm_pkg::*;
#(
    parameter int unsigned DIV = 320
) (
    input logic     clk,
    input logic     rst,
    input logic     tick,
    input logic     go_q,
    input core_st_t st,
    input logic     pwm_out
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)       since_q <= '0;
        else if (tick) since_q <= '0;
        else           since_q <= since_q + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick == (since_q == CW'(DIV - 1))) else $error("tick spacing"); // R9

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !go_q |=> !pwm_out) else $error("output high while stopped"); // R8

    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(pwm_out) |-> ($past(tick) || !$past(go_q))) else $error("edge off tick"); // R3

    AST_RISE_AT_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> ($past(st.cnt) == '0)) else $error("rise before underflow"); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm_out) && $past(go_q)) |-> ($past(st.cnt) == '1)) else $error("fall before overflow"); // R4

endmodule

bind dupwm_gen dupwm_gen_chk #(.DIV(DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .go_q    (go_q),
    .st      (core_st),
    .pwm_out (pwm_out)
);

// File: tb/dupwm_gen_tb.sv
`timescale 1ns/1ps
module dupwm_gen_tb;
    import dupwm_pkg::*;

    localparam int DIV  = 4;
    localparam int SPAN = 2 ** VAL_W;   // high phase = SPAN - V ticks

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic             wr_addr = 1'b0;
    logic [VAL_W-1:0] wr_data = '0;
    logic             pwm_out;

    dupwm_gen #(.DIV(DIV)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit    level;
        int    len;
        string req;
    } seg_t;

    seg_t q[$];
    int   total = 0;
    int   bad = 0;
    int   skip = 0;
    int   cyc = 0;
    int   last_edge = 0;
    bit   prev = 1'b0;
    bit   done = 1'b0;

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures each completed segment and compares it with the queue
    always @(negedge clk) begin
        cyc++;
        if (!rst && pwm_out !== prev) begin
            int   len;
            seg_t e;
            len = cyc - last_edge;
            if (skip > 0) begin
                skip--;
            end else if (q.size() > 0) begin
                e = q.pop_front();
                chk(prev == e.level && len == e.len, e.req, len, e.len);
            end else begin
                chk(1'b0, "R8 unexpected edge", len, 0);
            end
            last_edge = cyc;
            prev = pwm_out;
        end
    end

    task automatic wr(bit a, int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = VAL_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(bit lvl, int ticks, string r);
        seg_t s;
        s.level = lvl;
        s.len = ticks * DIV;
        s.req = r;
        q.push_back(s);
    endtask

    task automatic wait_empty();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic idle_low(int cycles, string r);
        repeat (cycles) @(negedge clk);
        chk(pwm_out == 1'b0, r, int'(pwm_out), 0);
    endtask

    // Sets the start bit and times the first low phase (R6)
    task automatic start_run(int v);
        int n;
        skip = 1;
        wr(1'b1, 1);
        n = 0;
        while (!pwm_out) begin
            @(negedge clk);
            n++;
        end
        chk(n >= v * DIV + 2 && n <= (v + 1) * DIV + 1, "R6 first low phase", n, (v + 1) * DIV);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(pwm_out == 1'b0, "R1 reset output", int'(pwm_out), 0);
        rst = 1'b0;
        idle_low(3 * DIV, "R1 after reset");

        // R2: value written and other control bits set, start bit clear
        wr(1'b0, 50);
        wr(1'b1, 8'hFE);
        idle_low(600 * DIV, "R2 stopped output");

        // R3 R4 R9: steady running with V=100
        wr(1'b0, 100);
        start_run(100);
        for (int i = 0; i < 3; i++) begin
            push(1'b1, SPAN - 100, "R4 R9 high phase V=100");
            if (i < 2) push(1'b0, 101, "R3 R9 low phase V=100");
        end
        wait_empty();
        wr(1'b1, 0);
        idle_low(2, "R8 stop in low phase");
        idle_low(300 * DIV, "R8 stays stopped");

        // R5: bottom boundary
        wr(1'b0, 0);
        start_run(0);
        push(1'b1, SPAN, "R5 high V=0");
        push(1'b0, 1, "R5 low V=0");
        push(1'b1, SPAN, "R5 high V=0");
        wait_empty();
        wr(1'b1, 0);
        idle_low(100 * DIV, "R8 after V=0");

        // R5: top boundary
        wr(1'b0, 255);
        start_run(255);
        push(1'b1, SPAN - 255, "R5 high V=255");
        push(1'b0, 256, "R5 low V=255");
        push(1'b1, SPAN - 255, "R5 high V=255");
        wait_empty();
        wr(1'b1, 0);
        idle_low(100 * DIV, "R8 after V=255");

        // R7: value changes inside a low phase and then inside a high phase
        wr(1'b0, 100);
        start_run(100);
        push(1'b1, SPAN - 100, "R7 high before change");
        push(1'b0, 101, "R7 low in progress keeps old value");
        push(1'b1, SPAN - 20, "R7 high after change");
        push(1'b0, 21, "R7 low after change");
        push(1'b1, SPAN - 20, "R7 high in progress keeps old value");
        push(1'b0, 201, "R7 low after second change");
        push(1'b1, SPAN - 200, "R7 high after second change");
        while (q.size() != 6) @(negedge clk);
        repeat (20) @(negedge clk);
        wr(1'b0, 20);
        while (q.size() != 3) @(negedge clk);
        repeat (20) @(negedge clk);
        wr(1'b0, 200);
        wait_empty();
        wr(1'b1, 0);
        idle_low(100 * DIV, "R8 after R7 run");

        // R8: stop in the middle of a high phase
        wr(1'b0, 128);
        start_run(128);
        repeat (10) @(negedge clk);
        skip = 1;
        wr(1'b1, 0);
        idle_low(1, "R8 stop in high phase");
        idle_low(300 * DIV, "R8 no edges after stop");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule